// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory holding 1024 bytes in an on-chip register array. It runs on a fast system clock and watches the bus clock and data line as plain sampled inputs. It drives the open-drain data line through one enable that pulls the line low. It finds start and stop conditions and checks a device-select byte against a four-bit family code and one hardwired address pin. It acknowledges every byte it accepts and serves byte writes, page writes, random reads and sequential reads.

Written bytes gather in a one-page buffer and are committed to the array at the stop condition. A self-timed busy period then follows, counted in system clocks. A write-protect input blocks the commit. A standby flag shows when the slave is idle and not busy. A master can bring a confused slave back by giving nine clocks with the data line released and then a start.

Top module: `eeprom_slave`

## Requirements
- R1: After reset the slave does not pull the data line low, `busy_o` is 0 and `standby_o` is 1.
- R2: A start (data falling while the bus clock is high) ends any transfer in progress, releases the data line and discards buffered write data. A stop (data rising while the bus clock is high) returns the slave to idle.
- R3: The first byte after a start is the device select, sent MSB first: bits 7:4 = 1010, bit 3 = the value of `a2_pin`, bits 2:1 = word-address bits 9:8, bit 0 = 1 for read and 0 for write. A byte with a different code or address pin bit gets no acknowledge, and the slave ignores the bus until the next start.
- R4: Each byte the slave accepts is acknowledged by pulling the data line low through the ninth bus clock.
- R5: Byte write: device select (write), word-address bits 7:0, one data byte, then a stop stores the byte at the 10-bit address.
- R6: Page write: each further data byte raises only address bits 3:0, which wrap from 15 to 0 inside the same 16-byte page. Bytes at other addresses stay unchanged.
- R7: Read: a device select with bit 0 = 1 returns bytes MSB first from the current address, which each byte advances across all 10 bits, rolling over from 1023 to 0. A master acknowledge asks for the next byte, and a missing acknowledge ends the read.
- R8: When `wp_i` is 1 at the stop, no byte is stored and no busy period starts.
- R9: A stop that ends a write with at least one data byte, while `wp_i` is 0, holds `busy_o` at 1 for exactly WR_CYCLES system clocks. A device select during that time gets no acknowledge.
- R10: After a broken transfer, nine bus clocks with the data line released leave the slave no longer pulling the line low. A following start restores normal operation.
- R11: The slave changes its data-line drive only after a falling bus clock edge.
- R12: `standby_o` is 1 only while the slave is idle and not busy. It is 0 during a transfer and 1 after the stop of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock, sampled |
| sda_i | input | 1 | Data line level as seen on the wire |
| a2_pin | input | 1 | Hardwired address pin compared with device-select bit 3 |
| wp_i | input | 1 | Write protect, 1 blocks all writes |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Self-timed write cycle in progress |
| standby_o | output | 1 | Idle and not busy |

## Verification
The assertions assume that the bus inputs are synchronous to the system clock, that each bus phase lasts several clocks, and that the bus clock and data line never change in the same clock. The rule that drive changes follow only falling bus clocks also assumes the master never issues a start or stop while the slave is pulling the line low. The bench drives both lines at falling system-clock edges and holds each level for four clocks. It changes data only while the bus clock is low, except for deliberate starts and stops. It models the wired-AND line from the master level and the slave's pull-down.

// File: rtl/eeprom_slave.sv
module eeprom_slave #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 1250000,
  parameter int DEV_CODE  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic a2_pin,
  input  logic wp_i,
  output logic sda_pull_o,
  output logic busy_o,
  output logic standby_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - 8;
  localparam int CODE_W = 6 - HI_W;
  localparam int CW     = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADR, S_WR, S_RD} st_t;

  st_t st;
  logic scl_q, sda_q, rd_q;
  logic [3:0] bits;
  logic [7:0] sr;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE-1:0] pmask;
  logic [CW-1:0] wcnt;
  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire dev_hit  = (sr[7:HI_W+2] == CODE_W'(DEV_CODE)) && (sr[HI_W+1] == a2_pin) && (wcnt == '0);
  wire commit   = stop_c && (st == S_WR) && (pmask != '0) && !wp_i;
  wire wr_byte  = !start_c && !stop_c && (st == S_WR) && scl_fall && (bits == 4'd8);
  wire [7:0] rd_byte = mem[ptr];

  assign busy_o    = (wcnt != '0);
  assign standby_o = (st == S_IDLE) && !busy_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      rd_q <= 1'b0;
      bits <= '0;
      sr <= '0;
      ptr <= '0;
      pmask <= '0;
      wcnt <= '0;
      sda_pull_o <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (wcnt != '0) wcnt <= wcnt - 1'b1;
      if (start_c) begin
        st <= S_DEV;
        bits <= '0;
        sda_pull_o <= 1'b0;
        pmask <= '0;
      end else if (stop_c) begin
        st <= S_IDLE;
        sda_pull_o <= 1'b0;
        pmask <= '0;
        if (commit) wcnt <= CW'(WR_CYCLES);
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          sr <= {sr[6:0], sda_i};
          if (bits != 4'd9) bits <= bits + 1'b1;
        end else if (scl_fall) begin
          if (st == S_RD) begin
            if (bits == 4'd8) begin
              sda_pull_o <= 1'b0;
              ptr <= ptr + 1'b1;
            end else if (bits == 4'd9) begin
              bits <= '0;
              if (sr[0]) st <= S_IDLE;
              else sda_pull_o <= ~rd_byte[7];
            end else if (bits != 4'd0) begin
              sda_pull_o <= ~rd_byte[~bits[2:0]];
            end
          end else if (bits == 4'd8) begin
            case (st)
              S_DEV: begin
                if (dev_hit) begin
                  sda_pull_o <= 1'b1;
                  rd_q <= sr[0];
                  ptr[ADDR_W-1:8] <= sr[HI_W:1];
                end else begin
                  st <= S_IDLE;
                end
              end
              S_ADR: begin
                sda_pull_o <= 1'b1;
                ptr[7:0] <= sr;
              end
              default: begin
                sda_pull_o <= 1'b1;
                pmask[ptr[PAGE_W-1:0]] <= 1'b1;
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
              end
            endcase
          end else if (bits == 4'd9) begin
            sda_pull_o <= 1'b0;
            bits <= '0;
            if (st == S_DEV) begin
              if (rd_q) begin
                st <= S_RD;
                sda_pull_o <= ~rd_byte[7];
              end else begin
                st <= S_ADR;
              end
            end else if (st == S_ADR) begin
              st <= S_WR;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_byte) pbuf[ptr[PAGE_W-1:0]] <= sr;
    if (commit)
      for (int i = 0; i < PAGE; i++)
        if (pmask[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
  end
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk #(
  parameter int WR_CYCLES = 1250000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic wp_i,
  input logic sda_pull_o,
  input logic busy_o,
  input logic standby_o
);
  int run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else if (busy_o) run <= run + 1;
    else run <= 0;
  end

  assert_drive_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_i));

  assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> !sda_pull_o);

  assert_wp_no_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(wp_i));

  assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run == WR_CYCLES));

  assert_standby_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> (!busy_o && !sda_pull_o));
endmodule

bind eeprom_slave eeprom_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (.*);

// File: tb/eeprom_slave_test.sv
module eeprom_slave_test;
  localparam int WR = 300;
  localparam logic A2 = 1'b1;
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {10'h001, 8'hA5}, {10'h123, 8'h3C}, {10'h2AA, 8'h00},
    {10'h355, 8'hFF}, {10'h0FF, 8'h81}, {10'h300, 8'h7E}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1, wp = 1'b0;
  logic sda_pull_o, busy_o, standby_o;
  wire sda_line = msda & ~sda_pull_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eeprom_slave #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .a2_pin(A2),
    .wp_i(wp), .sda_pull_o(sda_pull_o), .busy_o(busy_o), .standby_o(standby_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold(); repeat (4) @(negedge clk); endtask

  task automatic bstart();
    msda = 1'b1; hold(); scl = 1'b1; hold(); msda = 1'b0; hold(); scl = 1'b0; hold();
  endtask

  task automatic bstop();
    msda = 1'b0; hold(); scl = 1'b1; hold(); msda = 1'b1; hold();
  endtask

  task automatic clk_pulse(); hold(); scl = 1'b1; hold(); scl = 1'b0; endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; hold(); scl = 1'b1; hold(); scl = 1'b0;
    end
    hold(); msda = 1'b1; hold(); scl = 1'b1; hold();
    ack = ~sda_line;
    scl = 1'b0; hold();
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] b);
    msda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hold(); scl = 1'b1; hold(); b = {b[6:0], sda_line}; scl = 1'b0;
    end
    hold(); msda = ~give_ack; hold(); scl = 1'b1; hold(); scl = 1'b0; hold(); msda = 1'b1;
  endtask

  function automatic logic [7:0] ds(input logic [9:0] a, input logic rw);
    return {4'b1010, A2, a[9:8], rw};
  endfunction

  task automatic wait_idle(); while (busy_o) @(negedge clk); endtask

  task automatic bwrite(input logic [9:0] a, input logic [7:0] d, input string tag);
    logic k;
    bstart();
    send(ds(a, 1'b0), k); chk({tag, " devsel ack R4"}, k, 1'b1);
    send(a[7:0], k);      chk({tag, " addr ack R4"}, k, 1'b1);
    send(d, k);           chk({tag, " data ack R4"}, k, 1'b1);
    bstop();
  endtask

  task automatic rread(input logic [9:0] a, output logic [7:0] d);
    logic k;
    bstart(); send(ds(a, 1'b0), k); send(a[7:0], k);
    bstart(); send(ds(a, 1'b1), k); recv(1'b0, d); bstop();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic k;
    repeat (5) @(negedge clk);
    chk("R1 reset pull", sda_pull_o, 1'b0);
    chk("R1 reset busy", busy_o, 1'b0);
    chk("R1 reset standby", standby_o, 1'b1);
    rst_n = 1'b1; hold();

    // R5 / R7 table of byte writes read back at random addresses
    for (int v = 0; v < NV; v++) begin
      bwrite(VEC[v][17:8], VEC[v][7:0], "R5 vec");
      wait_idle();
      rread(VEC[v][17:8], d);
      chk("R5 R7 vec readback", d, VEC[v][7:0]);
    end

    // R9 busy after a write, device select refused while busy
    bwrite(10'h1F2, 8'h55, "R9 pre");
    chk("R9 busy after stop", busy_o, 1'b1);
    chk("R12 standby low while busy", standby_o, 1'b0);
    bstart(); send(ds(10'h000, 1'b0), k); bstop();
    chk("R9 nack while busy", k, 1'b0);
    wait_idle();
    chk("R9 busy ends", busy_o, 1'b0);

    // R6 page write wrapping from 0x1FE to 0x1F1
    bstart();
    send(ds(10'h1FE, 1'b0), k); send(8'hFE, k);
    send(8'hA0, k); send(8'hA1, k); send(8'hA2, k); send(8'hA3, k);
    chk("R6 page data ack", k, 1'b1);
    bstop(); wait_idle();
    rread(10'h1FE, d); chk("R6 first byte", d, 8'hA0);
    rread(10'h1FF, d); chk("R6 page end", d, 8'hA1);
    rread(10'h1F0, d); chk("R6 wrapped to page start", d, 8'hA2);
    rread(10'h1F1, d); chk("R6 wrapped second", d, 8'hA3);
    rread(10'h1F2, d); chk("R6 neighbour untouched", d, 8'h55);

    // R7 sequential read rolls over from 1023 to 0
    bwrite(10'h3FF, 8'h11, "R7 pre"); wait_idle();
    bwrite(10'h000, 8'h22, "R7 pre"); wait_idle();
    bstart(); send(ds(10'h3FF, 1'b0), k); send(8'hFF, k);
    bstart(); send(ds(10'h3FF, 1'b1), k);
    chk("R12 standby low in transfer", standby_o, 1'b0);
    recv(1'b1, d); recv(1'b0, d2); bstop();
    chk("R7 seq first", d, 8'h11);
    chk("R7 seq rollover", d2, 8'h22);
    chk("R12 standby after read stop", standby_o, 1'b1);

    // R8 write protect
    bwrite(10'h040, 8'hC3, "R8 pre"); wait_idle();
    wp = 1'b1;
    bwrite(10'h040, 8'h99, "R8 wp");
    chk("R8 no busy under wp", busy_o, 1'b0);
    wp = 1'b0;
    rread(10'h040, d); chk("R8 data kept", d, 8'hC3);

    // R3 device select mismatch
    bstart(); send({4'b1010, ~A2, 2'b00, 1'b0}, k); bstop();
    chk("R3 wrong pin nack", k, 1'b0);
    bstart(); send({4'b1011, A2, 2'b00, 1'b0}, k); bstop();
    chk("R3 wrong code nack", k, 1'b0);
    chk("R3 standby after nack", standby_o, 1'b1);

    // R2 start aborts a pending write
    bwrite(10'h080, 8'h10, "R2 pre"); wait_idle();
    bstart(); send(ds(10'h080, 1'b0), k); send(8'h80, k); send(8'h77, k);
    bstart(); bstop();
    chk("R2 no busy after abort", busy_o, 1'b0);
    rread(10'h080, d); chk("R2 aborted data discarded", d, 8'h10);

    // R10 recovery after a broken read
    bstart(); send(ds(10'h123, 1'b0), k); send(8'h23, k);
    bstart(); send(ds(10'h123, 1'b1), k);
    for (int i = 0; i < 3; i++) clk_pulse();
    msda = 1'b1;
    for (int i = 0; i < 9; i++) clk_pulse();
    hold();
    chk("R10 line released", sda_pull_o, 1'b0);
    bstart(); bstop();
    rread(10'h123, d); chk("R10 read after recovery", d, 8'h3C);

    done = 1;
    summary();
  end
endmodule